// File: doc/BRIEF.md
# Serial Combination Lock with Guidance Output

This block watches a single serial input, one bit per clock, and recognises a fixed unlock code. A small progress register records how many leading bits of the code the most recent inputs already match. When the seven bits received on earlier clocks were 0110111 and the bit now on the input is 0, the unlock output goes high in that same cycle. It is a Mealy output, so it depends on the registered progress and on the live input.

A second output, the guidance flag, is high when the bit now presented is the one that moves the lock closer to opening. A user, or a driving circuit, can use it to find the code one bit at a time. A wrong bit does not always throw away all progress. The lock falls back to the longest tail of the received stream that is still a valid start of the code. After a successful opening it continues by the same rule, so overlapping attempts are recognised.

The code is a parameter. The first bit received sits in the most significant position, and the final bit is the one that must be present on the unlock cycle. The progress register width is derived from the code length. Unused progress encodings return to the no-progress state.

Top module: `serial_code_lock`

## Requirements
- R1: Synchronous reset (active high) puts the lock in the no-progress state. Afterwards unlock is 0, and hint is 1 exactly when the input is 0, the first code bit.
- R2: unlock is 1 in a cycle if and only if the inputs on the seven preceding clocks since reset were 0,1,1,0,1,1,1 (oldest first) and the current input is 0.
- R3: With the seven preceding inputs equal to 0110111, a current input of 1 gives unlock 0. The next cycle also gives no unlock.
- R4: hint is 1 exactly when the current input equals the code bit that follows the longest suffix of the inputs since reset that is also a prefix of the code. The full code is 01101110, first bit leftmost.
- R5: On a wrong bit, progress drops to the longest suffix of the received stream that is a code prefix. Example: after 011011 and then 0, only 111 followed by 0 is needed to unlock.
- R6: After an unlock, the final 0 counts as the first code bit. Example: 01101110 followed by 1101110 unlocks a second time.
- R7: A reset in the middle of a partial code discards all progress. Inputs received before the reset never contribute to an unlock.
- R8: Over a long pseudo-random stream with the code inserted at intervals, unlock and hint agree every cycle with a reference model that keeps the last seven inputs in a shift register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial code input, one bit per clock |
| unlock | output | 1 | High while the code has been completed by the present bit |
| hint | output | 1 | High when the present bit advances toward unlocking |

## Verification
The bench builds the lock with its default eight-bit code 01101110. That code is rich in self-overlap: a miss after 011011 falls back to progress four, and a completed code leaves progress one. Those values bring the non-trivial fallback and the back-to-back unlock paths within reach of short directed sequences. Both values of the input are probed within a single cycle before each edge, so the guidance output is checked for the right bit and the wrong bit at every progress level. A pseudo-random stream with periodic code insertions is then compared against a seven-bit shift-register model.

// File: rtl/lock_pkg.sv
`timescale 1ns/1ps
package lock_pkg;

  // Bit idx of the code, idx 0 being the first bit received (stored at MSB).
  function automatic logic code_bit(input logic [31:0] key, input int len, input int idx);
    return key[len-1-idx];
  endfunction

  // Progress after seeing prefix of length k followed by x:
  // longest suffix of that stream (capped at len-1) that is also a code prefix.
  function automatic int advance(input logic [31:0] key, input int len,
                                 input int k, input logic x);
    int  best;
    int  pos;
    logic ok;
    logic sb;
    best = 0;
    for (int l = 1; l <= k + 1; l++) begin
      if (l <= len - 1) begin
        ok = 1'b1;
        for (int i = 0; i < l; i++) begin
          pos = k + 1 - l + i;
          sb  = (pos == k) ? x : code_bit(key, len, pos);
          if (sb != code_bit(key, len, i)) ok = 1'b0;
        end
        if (ok) best = l;
      end
    end
    return best;
  endfunction

endpackage

// File: rtl/lock_next_state.sv
`timescale 1ns/1ps
module lock_next_state #(
  parameter int          KEY_LEN = 8,
  parameter logic [31:0] KEY     = 32'b0110_1110,
  parameter int          W       = 3
) (
  input  logic [W-1:0] progress,
  input  logic         bit_in,
  output logic [W-1:0] progress_next
);
  import lock_pkg::*;

  localparam int NUM_CODES = 1 << W;

  logic [W-1:0] on_zero [NUM_CODES];
  logic [W-1:0] on_one  [NUM_CODES];

  for (genvar s = 0; s < NUM_CODES; s++) begin : g_state
    if (s < KEY_LEN) begin : g_used
      localparam int NXT0 = advance(KEY, KEY_LEN, s, 1'b0);
      localparam int NXT1 = advance(KEY, KEY_LEN, s, 1'b1);
      assign on_zero[s] = W'(NXT0);
      assign on_one[s]  = W'(NXT1);
    end else begin : g_unused
      // Unreachable encodings recover to the no-progress state.
      assign on_zero[s] = '0;
      assign on_one[s]  = '0;
    end
  end

  assign progress_next = bit_in ? on_one[progress] : on_zero[progress];

endmodule

// File: rtl/lock_progress_reg.sv
`timescale 1ns/1ps
module lock_progress_reg #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/lock_output_decode.sv
`timescale 1ns/1ps
module lock_output_decode #(
  parameter int          KEY_LEN = 8,
  parameter logic [31:0] KEY     = 32'b0110_1110,
  parameter int          W       = 3
) (
  input  logic [W-1:0] progress,
  input  logic         bit_in,
  output logic         hint,
  output logic         unlock
);
  import lock_pkg::*;

  localparam int NUM_CODES = 1 << W;
  localparam logic [W-1:0] FINAL_STATE = W'(KEY_LEN - 1);

  logic want_bit [NUM_CODES];
  logic in_use   [NUM_CODES];

  for (genvar s = 0; s < NUM_CODES; s++) begin : g_want
    if (s < KEY_LEN) begin : g_used
      localparam logic WB = code_bit(KEY, KEY_LEN, s);
      assign want_bit[s] = WB;
      assign in_use[s]   = 1'b1;
    end else begin : g_unused
      assign want_bit[s] = 1'b0;
      assign in_use[s]   = 1'b0;
    end
  end

  assign hint   = in_use[progress] && (bit_in == want_bit[progress]);
  assign unlock = (progress == FINAL_STATE) && (bit_in == KEY[0]);

endmodule

// File: rtl/serial_code_lock.sv
`timescale 1ns/1ps
module serial_code_lock #(
  parameter int          KEY_LEN = 8,
  parameter logic [31:0] KEY     = 32'b0110_1110
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  output logic unlock,
  output logic hint
);
  localparam int STATE_W = (KEY_LEN > 2) ? $clog2(KEY_LEN) : 1;

  logic [STATE_W-1:0] progress_q;
  logic [STATE_W-1:0] progress_d;

  lock_next_state #(.KEY_LEN(KEY_LEN), .KEY(KEY), .W(STATE_W)) next_i (
    .progress      (progress_q),
    .bit_in        (bit_in),
    .progress_next (progress_d)
  );

  lock_progress_reg #(.W(STATE_W)) state_i (
    .clk (clk),
    .rst (rst),
    .d   (progress_d),
    .q   (progress_q)
  );

  lock_output_decode #(.KEY_LEN(KEY_LEN), .KEY(KEY), .W(STATE_W)) out_i (
    .progress (progress_q),
    .bit_in   (bit_in),
    .hint     (hint),
    .unlock   (unlock)
  );

endmodule

// File: rtl/lock_checker.sv
`timescale 1ns/1ps
module lock_checker #(
  parameter int          KEY_LEN = 8,
  parameter logic [31:0] KEY     = 32'b0110_1110,
  parameter int          W       = 3
) (
  input logic         clk,
  input logic         rst,
  input logic         bit_in,
  input logic         unlock,
  input logic         hint,
  input logic [W-1:0] progress
);
  localparam logic [W-1:0] FINAL_STATE = W'(KEY_LEN - 1);

  // R1: reset leaves the no-progress state
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> progress == '0);

  // R2: an unlock needs the final code bit on the input
  a_r2_unlock_final_bit: assert property (@(posedge clk) disable iff (rst)
    unlock |-> bit_in == KEY[0]);

  // R2: an unlock only comes from the last progress level
  a_r2_unlock_at_end: assert property (@(posedge clk) disable iff (rst)
    unlock |-> progress == FINAL_STATE);

  // R4: the unlocking bit is always a guided bit
  a_r4_unlock_is_hinted: assert property (@(posedge clk) disable iff (rst)
    unlock |-> hint);

  // R4: a guided bit below the final level raises progress by one
  a_r4_hint_advances: assert property (@(posedge clk) disable iff (rst)
    (hint && progress != FINAL_STATE) |=> progress == $past(progress) + 1'b1);

  // R5: a wrong bit never raises progress
  a_r5_miss_no_gain: assert property (@(posedge clk) disable iff (rst)
    !hint |=> progress <= $past(progress));

  // R5: progress never reaches an unused encoding
  a_r5_progress_in_range: assert property (@(posedge clk) disable iff (rst)
    progress <= FINAL_STATE);
endmodule

bind serial_code_lock lock_checker #(.KEY_LEN(KEY_LEN), .KEY(KEY), .W(STATE_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .bit_in   (bit_in),
  .unlock   (unlock),
  .hint     (hint),
  .progress (progress_q)
);

// File: tb/serial_code_lock_tb_top.sv
`timescale 1ns/1ps
module serial_code_lock_tb_top;
  localparam logic [7:0] CODE = 8'b0110_1110;   // first bit received on the left

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in = 1'b0;
  logic unlock;
  logic hint;

  int errors = 0;
  int checks = 0;
  logic [6:0] hist = '0;  // hist[0] newest
  int cnt = 0;            // valid inputs since reset, saturating at 7
  logic obs_unlock;
  logic obs_hint;
  int unlocks_seen = 0;

  always #5 clk = ~clk;

  serial_code_lock dut_i (
    .clk    (clk),
    .rst    (rst),
    .bit_in (bit_in),
    .unlock (unlock),
    .hint   (hint)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ref_progress();
    int best = 0;
    for (int l = 1; l <= 7; l++) begin
      if (l <= cnt) begin
        logic ok = 1'b1;
        for (int i = 0; i < l; i++)
          if (hist[l-1-i] != CODE[7-i]) ok = 1'b0;
        if (ok) best = l;
      end
    end
    return best;
  endfunction

  function automatic logic ref_unlock(input logic x);
    return (cnt >= 7) && (hist == 7'b0110111) && (x == 1'b0);
  endfunction

  function automatic logic ref_hint(input logic x);
    return x == CODE[7 - ref_progress()];
  endfunction

  // Drive x, check both outputs against the model, optionally probe the other value, then clock.
  task automatic step(input logic x, input string req, input bit probe = 1'b0);
    @(negedge clk);
    if (probe) begin
      bit_in = ~x;
      #1;
      check(req, hint, ref_hint(~x));
      check(req, unlock, ref_unlock(~x));
    end
    bit_in = x;
    #1;
    obs_unlock = unlock;
    obs_hint   = hint;
    check(req, unlock, ref_unlock(x));
    check(req, hint, ref_hint(x));
    if (unlock) unlocks_seen++;
    @(posedge clk);
    hist = {hist[5:0], x};
    if (cnt < 7) cnt++;
  endtask

  task automatic feed(input logic [15:0] bits, input int n, input string req);
    for (int i = n - 1; i >= 0; i--) step(bits[i], req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    rst = 1'b0;
    hist = '0;
    cnt = 0;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    bit_in = 1'b0; #1;
    check("R1 hint on 0", hint, 1'b1);
    check("R1 unlock", unlock, 1'b0);
    bit_in = 1'b1; #1;
    check("R1 hint on 1", hint, 1'b0);
    check("R1 unlock on 1", unlock, 1'b0);
  endtask

  task automatic t_basic_unlock();
    do_reset();
    feed(16'b0110111, 7, "R2 prefix");
    check("R2 no early unlock", obs_unlock, 1'b0);
    step(1'b0, "R2 final");
    check("R2 unlock", obs_unlock, 1'b1);
  endtask

  task automatic t_wrong_final();
    do_reset();
    feed(16'b0110111, 7, "R3 prefix");
    step(1'b1, "R3 wrong final");
    check("R3 no unlock on 1", obs_unlock, 1'b0);
    step(1'b0, "R3 after");
    check("R3 no later unlock", obs_unlock, 1'b0);
  endtask

  task automatic t_hint_walk();
    do_reset();
    for (int i = 7; i >= 0; i--) begin
      step(CODE[i], "R4 walk", 1'b1);
      check("R4 hint on right bit", obs_hint, 1'b1);
    end
    check("R4 walk ends unlocked", obs_unlock, 1'b1);
  endtask

  task automatic t_fallback();
    do_reset();
    feed(16'b011011, 6, "R5 prefix");
    step(1'b0, "R5 miss", 1'b1);
    check("R5 miss no hint", obs_hint, 1'b0);
    feed(16'b111, 3, "R5 tail");
    step(1'b0, "R5 final");
    check("R5 unlock after fallback", obs_unlock, 1'b1);
  endtask

  task automatic t_overlap();
    do_reset();
    feed(16'b01101110, 8, "R6 first");
    check("R6 first unlock", obs_unlock, 1'b1);
    feed(16'b110111, 6, "R6 reuse");
    step(1'b0, "R6 second");
    check("R6 second unlock", obs_unlock, 1'b1);
  endtask

  task automatic t_reset_mid();
    do_reset();
    feed(16'b011011, 6, "R7 before");
    do_reset();
    feed(16'b110111, 6, "R7 after");
    step(1'b0, "R7 final");
    check("R7 no unlock from stale bits", obs_unlock, 1'b0);
  endtask

  task automatic t_stream();
    logic [15:0] lfsr = 16'hACE1;
    do_reset();
    unlocks_seen = 0;
    for (int n = 0; n < 3000; n++) begin
      if (n % 97 == 0) feed(16'b01101110, 8, "R8 stream");
      step(lfsr[0], "R8 stream");
      lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    end
    check("R8 unlocks occurred", unlocks_seen > 0, 1'b1);
  endtask

  bit done = 1'b0;

  initial begin
    t_reset();
    t_basic_unlock();
    t_wrong_final();
    t_hint_walk();
    t_fallback();
    t_overlap();
    t_reset_mid();
    t_stream();
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung expected done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule